// File: doc/BRIEF.md
# Call, Return and Interrupt-Return Sequencer

This block carries out the control-transfer side effects of five operations: a call through a register, the same call with a delay slot, a return, a return with a delay slot, and a return from interrupt. The caller presents an operation code together with the current program counter, the source register value, the status word, the link register and both stack pointers. A few cycles later the block reports the new program counter, the new status word, the new link value and the two new stack pointers.

Calls and returns are settled in one step and do not touch memory. A return from interrupt reads two words through a simple word read port. The first word is the return program counter and the second is the status word. The block waits on the port's ready signal before each advance. Bit `USTK_BIT` of the incoming status word chooses which stack pointer is popped: the supervisor pointer when the bit is 0, the user pointer when it is 1. Only the chosen pointer moves. A one-cycle `done` pulse marks the cycle in which all results are valid. A `slot_pending` flag tells the pipeline to execute a delay-slot instruction.

Top module: `tsq_seq`

## Requirements
- R1: Op code 0 (call) sets new_pc to src_in and new_rp to pc_in + 2. new_ps, new_ssp and new_usp equal their inputs. slot_pending is 0.
- R2: Op code 1 (delayed call) sets new_pc to src_in and new_rp to pc_in + 4. slot_pending is 1. The status word and stack pointers pass through unchanged.
- R3: Op code 2 (return) and op code 3 (delayed return) set new_pc to rp_in and leave new_rp equal to rp_in. slot_pending is 1 only for code 3. The status word and stack pointers pass through unchanged.
- R4: Op code 4 (return from interrupt) with status bit USTK_BIT (default 5) at 0 reads at ssp_in and then at ssp_in + 4. new_ssp is ssp_in + 8 and new_usp equals usp_in.
- R5: Op code 4 with status bit USTK_BIT at 1 reads at usp_in and then at usp_in + 4. new_usp is usp_in + 8 and new_ssp equals ssp_in.
- R6: On a return from interrupt, new_pc is the first word read and new_ps is the second. new_rp equals rp_in and slot_pending is 0.
- R7: While mem_ready is low, mem_rd stays high and mem_addr holds its value. The sequence does not advance.
- R8: Latency is counted from the clock edge that accepts the request. For codes 0 to 3, done is high in the cycle that follows. For code 4 with mem_ready held high, done is high in the third cycle after acceptance, so the operation spans four cycles in total.
- R9: A request with op code 5, 6 or 7 is ignored: busy stays low and no read or done follows. A request made while busy is also ignored and does not change the result of the operation in flight.
- R10: After reset, busy, done and mem_rd are 0.
- R11: done is high for exactly one cycle per accepted operation. busy is high from the cycle after acceptance through the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Request strobe, taken when idle |
| op_code | input | 3 | 0 call, 1 delayed call, 2 return, 3 delayed return, 4 return from interrupt |
| pc_in | input | XLEN | Address of the current instruction |
| src_in | input | XLEN | Source register value (call target) |
| ps_in | input | XLEN | Current status word |
| rp_in | input | XLEN | Current link register |
| ssp_in | input | XLEN | Current supervisor stack pointer |
| usp_in | input | XLEN | Current user stack pointer |
| mem_addr | output | XLEN | Word read address |
| mem_rd | output | 1 | Read strobe |
| mem_rdata | input | XLEN | Read data |
| mem_ready | input | 1 | Read completes in this cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Results valid in this cycle |
| slot_pending | output | 1 | Delay-slot instruction must execute |
| new_pc | output | XLEN | Resulting program counter |
| new_ps | output | XLEN | Resulting status word |
| new_rp | output | XLEN | Resulting link register |
| new_ssp | output | XLEN | Resulting supervisor stack pointer |
| new_usp | output | XLEN | Resulting user stack pointer |

## Verification
The bench builds the block with its defaults: 32-bit words, a 4-byte pop step, a 2-byte instruction size and the stack select at status bit 5. The random status words therefore exercise both stack choices, and the random stack pointers reach carry across the upper address bits. The memory model returns a value derived from each address, so swapped pop order, a wrong pointer or a wrong step shows up in new_pc or new_ps. Ready is stalled at random on half the operations to exercise the waits in both pop states.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

    typedef enum logic [1:0] {
        K_CALL = 2'd0,
        K_RET  = 2'd1,
        K_RETI = 2'd2
    } xfer_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_POP_PC = 2'd1,
        ST_POP_PS = 2'd2,
        ST_DONE   = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic       legal;
        xfer_kind_e kind;
        logic       delayed;
    } op_ctl_t;

    localparam logic [2:0] OPC_CALL   = 3'd0;
    localparam logic [2:0] OPC_CALL_D = 3'd1;
    localparam logic [2:0] OPC_RET    = 3'd2;
    localparam logic [2:0] OPC_RET_D  = 3'd3;
    localparam logic [2:0] OPC_RETI   = 3'd4;

    function automatic op_ctl_t decode_op(input logic [2:0] code);
        op_ctl_t c;
        c.legal   = 1'b1;
        c.kind    = K_CALL;
        c.delayed = 1'b0;
        case (code)
            OPC_CALL:   c.kind = K_CALL;
            OPC_CALL_D: begin c.kind = K_CALL; c.delayed = 1'b1; end
            OPC_RET:    c.kind = K_RET;
            OPC_RET_D:  begin c.kind = K_RET;  c.delayed = 1'b1; end
            OPC_RETI:   c.kind = K_RETI;
            default:    c.legal = 1'b0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/tsq_decode.sv
module tsq_decode
    import tsq_pkg::*;
(
    input  logic [2:0] op_code,
    output op_ctl_t    ctl
);
    always_comb ctl = decode_op(op_code);
endmodule

// File: rtl/tsq_link.sv
module tsq_link
    import tsq_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int INSN_BYTES = 2
) (
    input  xfer_kind_e      kind,
    input  logic            delayed,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] src,
    input  logic [XLEN-1:0] rp,
    output logic [XLEN-1:0] tgt_pc,
    output logic [XLEN-1:0] link_val
);
    localparam logic [XLEN-1:0] NEAR_STEP = XLEN'(INSN_BYTES);
    localparam logic [XLEN-1:0] FAR_STEP  = XLEN'(2 * INSN_BYTES);

    always_comb begin
        tgt_pc   = pc;
        link_val = rp;
        case (kind)
            K_CALL: begin
                tgt_pc   = src;
                link_val = pc + (delayed ? FAR_STEP : NEAR_STEP);
            end
            K_RET:   tgt_pc = rp;
            default: tgt_pc = pc;
        endcase
    end
endmodule

// File: rtl/tsq_stack.sv
module tsq_stack #(
    parameter int XLEN       = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic            sel_user_in,
    input  logic [XLEN-1:0] ssp_in,
    input  logic [XLEN-1:0] usp_in,
    output logic [XLEN-1:0] base_sp,
    input  logic [XLEN-1:0] work_sp,
    output logic [XLEN-1:0] step_sp,
    input  logic            popping,
    input  logic            sel_user,
    input  logic [XLEN-1:0] held_ssp,
    input  logic [XLEN-1:0] held_usp,
    output logic [XLEN-1:0] out_ssp,
    output logic [XLEN-1:0] out_usp
);
    localparam logic [XLEN-1:0] WSTEP = XLEN'(WORD_BYTES);

    always_comb begin
        base_sp = sel_user_in ? usp_in : ssp_in;
        step_sp = work_sp + WSTEP;
        out_ssp = (popping && !sel_user) ? work_sp : held_ssp;
        out_usp = (popping &&  sel_user) ? work_sp : held_usp;
    end
endmodule

// File: rtl/tsq_fsm.sv
module tsq_fsm
    import tsq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       start_pop,
    input  logic       mem_ready,
    output seq_state_e state
);
    seq_state_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:   if (start) nxt = start_pop ? ST_POP_PC : ST_DONE;
            ST_POP_PC: if (mem_ready) nxt = ST_POP_PS;
            ST_POP_PS: if (mem_ready) nxt = ST_DONE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/tsq_seq.sv
module tsq_seq
    import tsq_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int USTK_BIT   = 5,
    parameter int WORD_BYTES = 4,
    parameter int INSN_BYTES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            op_valid,
    input  logic [2:0]      op_code,
    input  logic [XLEN-1:0] pc_in,
    input  logic [XLEN-1:0] src_in,
    input  logic [XLEN-1:0] ps_in,
    input  logic [XLEN-1:0] rp_in,
    input  logic [XLEN-1:0] ssp_in,
    input  logic [XLEN-1:0] usp_in,
    output logic [XLEN-1:0] mem_addr,
    output logic            mem_rd,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic            mem_ready,
    output logic            busy,
    output logic            done,
    output logic            slot_pending,
    output logic [XLEN-1:0] new_pc,
    output logic [XLEN-1:0] new_ps,
    output logic [XLEN-1:0] new_rp,
    output logic [XLEN-1:0] new_ssp,
    output logic [XLEN-1:0] new_usp
);
    op_ctl_t         ctl;
    seq_state_e      state;
    logic            accept;
    logic [XLEN-1:0] link_tgt, link_val, base_sp, step_sp;

    xfer_kind_e      ctx_kind;
    logic            ctx_delayed, ctx_user;
    logic [XLEN-1:0] ctx_ssp, ctx_usp;
    logic [XLEN-1:0] res_pc, res_ps, res_rp, work_sp;

    tsq_decode u_dec (.op_code(op_code), .ctl(ctl));

    assign accept = op_valid && ctl.legal && (state == ST_IDLE);

    tsq_fsm u_fsm (
        .clk(clk), .rst(rst), .start(accept),
        .start_pop(ctl.kind == K_RETI), .mem_ready(mem_ready), .state(state)
    );

    tsq_link #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_link (
        .kind(ctl.kind), .delayed(ctl.delayed), .pc(pc_in), .src(src_in),
        .rp(rp_in), .tgt_pc(link_tgt), .link_val(link_val)
    );

    tsq_stack #(.XLEN(XLEN), .WORD_BYTES(WORD_BYTES)) u_stk (
        .sel_user_in(ps_in[USTK_BIT]), .ssp_in(ssp_in), .usp_in(usp_in),
        .base_sp(base_sp), .work_sp(work_sp), .step_sp(step_sp),
        .popping(ctx_kind == K_RETI), .sel_user(ctx_user),
        .held_ssp(ctx_ssp), .held_usp(ctx_usp),
        .out_ssp(new_ssp), .out_usp(new_usp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_kind    <= K_CALL;
            ctx_delayed <= 1'b0;
            ctx_user    <= 1'b0;
            ctx_ssp     <= '0;
            ctx_usp     <= '0;
            res_pc      <= '0;
            res_ps      <= '0;
            res_rp      <= '0;
            work_sp     <= '0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    ctx_kind    <= ctl.kind;
                    ctx_delayed <= ctl.delayed;
                    ctx_user    <= ps_in[USTK_BIT];
                    ctx_ssp     <= ssp_in;
                    ctx_usp     <= usp_in;
                    res_pc      <= link_tgt;
                    res_ps      <= ps_in;
                    res_rp      <= link_val;
                    work_sp     <= base_sp;
                end
                ST_POP_PC: if (mem_ready) begin
                    res_pc  <= mem_rdata;
                    work_sp <= step_sp;
                end
                ST_POP_PS: if (mem_ready) begin
                    res_ps  <= mem_rdata;
                    work_sp <= step_sp;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        busy         = (state != ST_IDLE);
        done         = (state == ST_DONE);
        mem_rd       = (state == ST_POP_PC) || (state == ST_POP_PS);
        mem_addr     = work_sp;
        slot_pending = ctx_delayed;
        new_pc       = res_pc;
        new_ps       = res_ps;
        new_rp       = res_rp;
    end
endmodule

// File: rtl/tsq_checker.sv
module tsq_checker #(
    parameter int XLEN       = 32,
    parameter int WORD_BYTES = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            op_valid,
    input logic [2:0]      op_code,
    input logic            busy,
    input logic            done,
    input logic            mem_rd,
    input logic            mem_ready,
    input logic [XLEN-1:0] mem_addr,
    input logic [XLEN-1:0] mem_rdata,
    input logic [XLEN-1:0] new_pc,
    input logic [1:0]      state_q
);
    localparam logic [XLEN-1:0] WSTEP = XLEN'(WORD_BYTES);
    localparam logic [1:0] S_POP_PC = 2'd1;

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_rd && !done));

    assert_read_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

    assert_first_word_pc_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_POP_PC && mem_ready) |=> (new_pc == $past(mem_rdata)));

    assert_pop_step_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_POP_PC && mem_ready) |=> (mem_addr == $past(mem_addr) + WSTEP));

    assert_quick_done_R8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !busy && op_code < 3'd4) |=> done);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_bad_code_R9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !busy && op_code > 3'd4) |=> !busy);
endmodule

bind tsq_seq tsq_checker #(.XLEN(XLEN), .WORD_BYTES(WORD_BYTES)) u_chk (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .busy(busy), .done(done), .mem_rd(mem_rd), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .new_pc(new_pc),
    .state_q(state)
);

// File: tb/sim_tsq_seq.sv
module sim_tsq_seq;
    localparam int CLK_PERIOD = 10;
    localparam int SBIT = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [31:0] pc_in = '0, src_in = '0, ps_in = '0, rp_in = '0, ssp_in = '0, usp_in = '0;
    logic [31:0] mem_addr, mem_rdata, new_pc, new_ps, new_rp, new_ssp, new_usp;
    logic        mem_rd, mem_ready = 1'b1, busy, done, slot_pending;

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    int done_cnt = 0;
    logic [31:0] rd_log [0:7];

    always #(CLK_PERIOD/2) clk = ~clk;

    tsq_seq u0 (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .pc_in(pc_in), .src_in(src_in), .ps_in(ps_in), .rp_in(rp_in),
        .ssp_in(ssp_in), .usp_in(usp_in), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .busy(busy), .done(done),
        .slot_pending(slot_pending), .new_pc(new_pc), .new_ps(new_ps),
        .new_rp(new_rp), .new_ssp(new_ssp), .new_usp(new_usp)
    );

    function automatic logic [31:0] memf(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, ~a[31:16]} + a;
    endfunction

    always_comb mem_rdata = memf(mem_addr);

    always @(posedge clk) begin
        if (mem_rd && mem_ready) begin
            if (rd_cnt < 8) rd_log[rd_cnt] <= mem_addr;
            rd_cnt <= rd_cnt + 1;
        end
        if (done) done_cnt <= done_cnt + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issues one operation and compares all results against the requirements.
    task automatic run_op(input logic [2:0] code, input logic [31:0] pc, src, ps, rp,
                          ssp, usp, input bit stall);
        logic [31:0] e_pc, e_ps, e_rp, e_ssp, e_usp, base;
        logic        e_slot;
        int          n;
        string       tag;
        e_pc = pc; e_ps = ps; e_rp = rp; e_ssp = ssp; e_usp = usp; e_slot = 1'b0;
        base = ps[SBIT] ? usp : ssp;
        case (code)
            3'd0: begin e_pc = src; e_rp = pc + 32'd2; tag = "R1"; end
            3'd1: begin e_pc = src; e_rp = pc + 32'd4; e_slot = 1'b1; tag = "R2"; end
            3'd2: begin e_pc = rp; tag = "R3"; end
            3'd3: begin e_pc = rp; e_slot = 1'b1; tag = "R3"; end
            default: begin
                e_pc = memf(base); e_ps = memf(base + 32'd4);
                if (ps[SBIT]) begin e_usp = usp + 32'd8; tag = "R5"; end
                else begin e_ssp = ssp + 32'd8; tag = "R4"; end
            end
        endcase
        @(negedge clk);
        rd_cnt = 0; done_cnt = 0;
        op_code = code; pc_in = pc; src_in = src; ps_in = ps; rp_in = rp;
        ssp_in = ssp; usp_in = usp; op_valid = 1'b1;
        mem_ready = stall ? (($urandom % 3) != 0) : 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        n = 1;
        while (!done && n < 60) begin
            mem_ready = stall ? (($urandom % 3) != 0) : 1'b1;
            @(negedge clk);
            n++;
        end
        chk({tag, " done"}, 32'(done), 32'd1);
        chk({tag, " new_pc"}, new_pc, e_pc);
        chk({tag, " new_ps"}, new_ps, e_ps);
        chk({tag, " new_rp"}, new_rp, e_rp);
        chk({tag, " new_ssp"}, new_ssp, e_ssp);
        chk({tag, " new_usp"}, new_usp, e_usp);
        chk({tag, " slot_pending"}, 32'(slot_pending), 32'(e_slot));
        if (!stall) chk("R8 latency", n, (code == 3'd4) ? 3 : 1);
        if (code == 3'd4) begin
            chk("R6 read count", rd_cnt, 2);
            chk({tag, " first pop addr"}, rd_log[0], base);
            chk({tag, " second pop addr"}, rd_log[1], base + 32'd4);
        end else begin
            chk("R1 no reads on call or return", rd_cnt, 0);
        end
        mem_ready = 1'b1;
        @(negedge clk);
        chk("R11 done single pulse", 32'(done), 32'd0);
        chk("R11 busy clear after done", 32'(busy), 32'd0);
        chk("R11 one done per op", done_cnt, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 busy after reset", 32'(busy), 32'd0);
        chk("R10 done after reset", 32'(done), 32'd0);
        chk("R10 read after reset", 32'(mem_rd), 32'd0);

        run_op(3'd0, 32'h0000_1000, 32'h0000_8000, 32'h0, 32'h11, 32'h2000, 32'h3000, 1'b0);
        run_op(3'd1, 32'h0000_1000, 32'h0000_8000, 32'h0, 32'h11, 32'h2000, 32'h3000, 1'b0);
        run_op(3'd2, 32'h0000_1000, 32'h0, 32'h20, 32'h0000_4444, 32'h2000, 32'h3000, 1'b0);
        run_op(3'd3, 32'h0000_1000, 32'h0, 32'h0, 32'h0000_4444, 32'h2000, 32'h3000, 1'b0);
        run_op(3'd4, 32'h0, 32'h0, 32'h0000_0000, 32'h5, 32'h0000_2000, 32'h0000_3000, 1'b0);
        run_op(3'd4, 32'h0, 32'h0, 32'h0000_0020, 32'h5, 32'h0000_2000, 32'h0000_3000, 1'b0);
        run_op(3'd0, 32'hFFFF_FFFE, 32'h4, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0);
        run_op(3'd4, 32'h0, 32'h0, 32'h0, 32'h0, 32'hFFFF_FFF8, 32'h0, 1'b0);

        // R7: long stall in the first pop, address must hold
        @(negedge clk);
        rd_cnt = 0;
        op_code = 3'd4; ps_in = 32'h20; usp_in = 32'h0000_7700; ssp_in = 32'h100;
        op_valid = 1'b1; mem_ready = 1'b0;
        @(negedge clk);
        op_valid = 1'b0;
        for (int i = 0; i < 5; i++) begin
            chk("R7 read held during stall", 32'(mem_rd), 32'd1);
            chk("R7 address held during stall", mem_addr, 32'h0000_7700);
            @(negedge clk);
        end
        // R9: a call while busy is ignored
        op_code = 3'd0; src_in = 32'hDEAD_0000; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0; mem_ready = 1'b1;
        while (!done) @(negedge clk);
        chk("R9 busy request ignored pc", new_pc, memf(32'h0000_7700));
        chk("R9 busy request ignored rp", new_rp, rp_in);
        @(negedge clk);
        chk("R9 no second done", 32'(done), 32'd0);

        // R9: unsupported codes
        for (int c = 5; c < 8; c++) begin
            @(negedge clk);
            rd_cnt = 0; done_cnt = 0;
            op_code = 3'(c); op_valid = 1'b1;
            @(negedge clk);
            op_valid = 1'b0;
            chk("R9 bad code busy", 32'(busy), 32'd0);
            repeat (3) @(negedge clk);
            chk("R9 bad code no done", done_cnt, 0);
            chk("R9 bad code no read", rd_cnt, 0);
        end

        for (int k = 0; k < 60; k++) begin
            run_op(3'($urandom % 5), $urandom, $urandom, $urandom, $urandom,
                   {$urandom} & 32'hFFFF_FFFC, {$urandom} & 32'hFFFF_FFFC, (k % 2) == 1);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule